// File: doc/BRIEF.md
# DDR Read-Enable Position Trainer

This block sits beside a DDR read path. Its job is to find where the read-enable window has to sit for one data-strobe group. It works by trial: it asks a command sequencer for reads, one at a time. For each read it drives a read-enable pulse and presents a candidate position. The position has two parts: a 2-bit fine phase code and a 3-bit coarse clock-select code. The block then watches the capture logic's data-valid and burst-detect flags. A pass at one position is not enough. A run of consecutive passes there is needed before that position is adopted. A miss clears the run and moves the search to the next position.

A pulse on the start input launches training. The same input is used after initialization and again later for periodic recalibration. While a recalibration runs, the adopted position and the done flag keep their previous values, so normal traffic never sees a half-tested setting. If every position has been tried without success, the block raises fail and keeps whatever it had adopted before.

Top module: `rdq_read_train`

## Requirements
- R1: For every accepted read, `rd_en_o` goes high in the cycle after `rd_ack_i` is sampled high. It stays high for exactly BURST_LEN/4 cycles. BURST_LEN must be a multiple of 8 and at least 8, so each training access covers at least eight beats.
- R2: After a read is accepted, `rd_req_o` stays low while the block waits for `dvalid_i`. It also stays low in the following cycle, in which `bdet_i` is sampled. A new request can appear, at the earliest, in the cycle after that sample.
- R3: When `bdet_i` is high at the sample point, it counts as a pass. When PASS_TARGET consecutive passes occur at one position, that position is copied to `lock_phase_o`/`lock_csel_o` and `done_o` is set. At the same time `busy_o` falls in the cycle after the last sample.
- R4: When `bdet_i` is low at the sample point, it counts as a miss. A miss clears the pass run, and the next request uses the next position.
- R5: Each training starts at phase 0, clock select 0. The search visits phases 0 to 3 within one clock-select value. It then increments clock select and sets the phase back to 0. Read as the 5-bit number {csel, phase}, the trial position increases by one per miss.
- R6: A miss at phase 3, clock select 7 ends training. In the next cycle `fail_o` is high and `busy_o` is low. `done_o` and the lock outputs keep their previous values.
- R7: If `dvalid_i` stays low for TIMEOUT cycles after the accept cycle, that read is a miss. The next request (or the end of training) shows TIMEOUT cycles after the first cycle following the accept.
- R8: `start_i` while idle begins training: in the next cycle `busy_o` is high, `fail_o` is low and the trial position is 0. `start_i` while busy has no effect on the search order.
- R9: While `busy_o` is high, `lock_phase_o`, `lock_csel_o` and `done_o` do not change.
- R10: After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to train or recalibrate (used when idle) |
| busy_o | output | 1 | Training in progress |
| rd_req_o | output | 1 | Asks the sequencer for one training read |
| rd_ack_i | input | 1 | Sequencer accepted the read (one cycle) |
| rd_en_o | output | 1 | Read-enable pulse, BURST_LEN/4 cycles per read |
| dvalid_i | input | 1 | Data-valid flag from the capture logic |
| bdet_i | input | 1 | Burst-detect flag from the capture logic |
| rd_phase_o | output | PHASE_W | Trial fine phase code |
| rd_csel_o | output | CSEL_W | Trial coarse clock-select code |
| done_o | output | 1 | An adopted position is valid |
| fail_o | output | 1 | Last training exhausted all positions |
| lock_phase_o | output | PHASE_W | Adopted fine phase |
| lock_csel_o | output | CSEL_W | Adopted clock select |

## Verification
The embedded checks assume that the sequencer acknowledges only while a request is pending. They also assume that a new acknowledge never arrives while the previous read-enable pulse is still running. Finally, they assume that no step is requested once the last position is reached. The bench keeps to these rules in three ways. It raises `rd_ack_i` only after seeing `rd_req_o`, for one cycle. It places `dvalid_i` at least one cycle after the accept. It holds `bdet_i` stable from the sample until the next accept. Random targets, window widths, injected single misses and silent reads (no data-valid) vary the search path without breaking these rules.

// File: rtl/rdq_train_pkg.sv
// Package: shared state encoding for the read-enable position trainer.
package rdq_train_pkg;
    // Trainer sequencing states
    typedef enum logic [1:0] {
        TS_IDLE   = 2'd0,
        TS_REQ    = 2'd1,
        TS_WAIT   = 2'd2,
        TS_SAMPLE = 2'd3
    } tr_state_e;
endpackage

// File: rtl/rdq_re_pulse.sv
// Module: rdq_re_pulse
// Produces the read-enable window: high for BURST_LEN/4 cycles starting the
// cycle after fire_i. Assumes fire_i never arrives while a window is running.
module rdq_re_pulse #(
    parameter int unsigned BURST_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic re_o
);
    localparam int unsigned RE_CYCLES = BURST_LEN / 4;
    localparam int unsigned CW        = $clog2(RE_CYCLES + 1);
    localparam int unsigned RW        = $clog2(RE_CYCLES + 2);

    generate
        if (BURST_LEN < 8 || (BURST_LEN % 8) != 0) begin : g_bad_len
            $error("BURST_LEN must be a multiple of 8 and at least 8");
        end
    endgenerate

    logic [CW-1:0] left_q;

    // Remaining cycles of the current read-enable window
    always_ff @(posedge clk) begin
        if (!rst_n)          left_q <= '0;
        else if (fire_i)     left_q <= CW'(RE_CYCLES);
        else if (left_q != 0) left_q <= left_q - 1'b1;
    end

    assign re_o = (left_q != '0);

    // Independent run-length counter used only by the checks below
    logic [RW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (re_o) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    p_re_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(re_o) |-> (run_q == RW'(RE_CYCLES)));

    p_fire_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |-> !re_o);
endmodule

// File: rtl/rdq_pos_stepper.sv
// Module: rdq_pos_stepper
// Holds the trial position as one counter whose low bits are the fine phase
// and high bits the clock select, so phase sweeps first. Assumes step_i is
// never raised on the last position.
module rdq_pos_stepper #(
    parameter int unsigned PHASE_W = 2,
    parameter int unsigned CSEL_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               step_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic [CSEL_W-1:0]  csel_o,
    output logic               last_o
);
    localparam int unsigned PW = PHASE_W + CSEL_W;

    logic [PW-1:0] pos_q;

    // Trial position: cleared at training start, advanced once per miss
    always_ff @(posedge clk) begin
        if (!rst_n)       pos_q <= '0;
        else if (clear_i) pos_q <= '0;
        else if (step_i)  pos_q <= pos_q + 1'b1;
    end

    assign phase_o = pos_q[PHASE_W-1:0];
    assign csel_o  = pos_q[PW-1:PHASE_W];
    assign last_o  = &pos_q;

    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> !last_o);
endmodule

// File: rtl/rdq_train_fsm.sv
// Module: rdq_train_fsm
// Sequences one training read at a time: request, wait for data-valid (with
// timeout), sample burst-detect one cycle later, then count a pass or a miss.
// Assumes rd_ack_i is only high while rd_req_o is high.
module rdq_train_fsm
    import rdq_train_pkg::*;
#(
    parameter int unsigned PASS_TARGET = 128,
    parameter int unsigned TIMEOUT     = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic rd_ack_i,
    input  logic dvalid_i,
    input  logic bdet_i,
    input  logic last_i,
    output logic rd_req_o,
    output logic busy_o,
    output logic fire_o,
    output logic clear_o,
    output logic step_o,
    output logic lock_o,
    output logic fail_o
);
    localparam int unsigned PASS_W = $clog2(PASS_TARGET + 1);
    localparam int unsigned TO_W   = $clog2(TIMEOUT + 1);

    generate
        if (PASS_TARGET < 1 || TIMEOUT < 2) begin : g_bad_cfg
            $error("PASS_TARGET must be >= 1 and TIMEOUT >= 2");
        end
    endgenerate

    tr_state_e         st_q, st_d;
    logic [PASS_W-1:0] pass_q;
    logic [TO_W-1:0]   to_q;
    logic              to_exp, hit, miss, exhaust;

    // Event decode for the current state
    always_comb begin
        fire_o  = (st_q == TS_REQ) && rd_ack_i;
        clear_o = (st_q == TS_IDLE) && start_i;
        to_exp  = (st_q == TS_WAIT) && !dvalid_i && (to_q == TO_W'(TIMEOUT - 1));
        hit     = (st_q == TS_SAMPLE) && bdet_i;
        miss    = ((st_q == TS_SAMPLE) && !bdet_i) || to_exp;
        lock_o  = hit && (pass_q == PASS_W'(PASS_TARGET - 1));
        step_o  = miss && !last_i;
        exhaust = miss && last_i;
    end

    // Next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TS_IDLE:   if (start_i) st_d = TS_REQ;
            TS_REQ:    if (rd_ack_i) st_d = TS_WAIT;
            TS_WAIT:   if (dvalid_i) st_d = TS_SAMPLE;
                       else if (to_exp) st_d = TS_REQ;
            TS_SAMPLE: st_d = TS_REQ;
            default:   st_d = TS_IDLE;
        endcase
        if (lock_o || exhaust) st_d = TS_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TS_IDLE;
        else        st_q <= st_d;
    end

    // Consecutive-pass run at the current position
    always_ff @(posedge clk) begin
        if (!rst_n)                 pass_q <= '0;
        else if (clear_o || miss || lock_o) pass_q <= '0;
        else if (hit)               pass_q <= pass_q + 1'b1;
    end

    // Cycles spent waiting for data-valid in the current read
    always_ff @(posedge clk) begin
        if (!rst_n)               to_q <= '0;
        else if (st_q != TS_WAIT) to_q <= '0;
        else                      to_q <= to_q + 1'b1;
    end

    // Exhaustion flag: set when the last position misses, cleared on start
    always_ff @(posedge clk) begin
        if (!rst_n)       fail_o <= 1'b0;
        else if (clear_o) fail_o <= 1'b0;
        else if (exhaust) fail_o <= 1'b1;
    end

    assign rd_req_o = (st_q == TS_REQ);
    assign busy_o   = (st_q != TS_IDLE);

    p_sample_after_dv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_SAMPLE) |-> $past(dvalid_i));

    p_ack_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack_i |-> rd_req_o);

    p_timeout_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_WAIT) |-> (to_q < TO_W'(TIMEOUT)));
endmodule

// File: rtl/rdq_read_train.sv
// Module: rdq_read_train (top)
// Closed-loop trainer for one strobe group's read-enable position. Ties the
// sequencer, position stepper and pulse generator together and keeps the
// adopted position stable until a new one is confirmed.
module rdq_read_train #(
    parameter int unsigned BURST_LEN   = 8,
    parameter int unsigned PASS_TARGET = 128,
    parameter int unsigned TIMEOUT     = 64,
    parameter int unsigned PHASE_W     = 2,
    parameter int unsigned CSEL_W      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    output logic               busy_o,
    output logic               rd_req_o,
    input  logic               rd_ack_i,
    output logic               rd_en_o,
    input  logic               dvalid_i,
    input  logic               bdet_i,
    output logic [PHASE_W-1:0] rd_phase_o,
    output logic [CSEL_W-1:0]  rd_csel_o,
    output logic               done_o,
    output logic               fail_o,
    output logic [PHASE_W-1:0] lock_phase_o,
    output logic [CSEL_W-1:0]  lock_csel_o
);
    localparam int unsigned PW = PHASE_W + CSEL_W;

    logic fire, clear, step, lock_evt, last;

    rdq_train_fsm #(
        .PASS_TARGET (PASS_TARGET),
        .TIMEOUT     (TIMEOUT)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .rd_ack_i (rd_ack_i),
        .dvalid_i (dvalid_i),
        .bdet_i   (bdet_i),
        .last_i   (last),
        .rd_req_o (rd_req_o),
        .busy_o   (busy_o),
        .fire_o   (fire),
        .clear_o  (clear),
        .step_o   (step),
        .lock_o   (lock_evt),
        .fail_o   (fail_o)
    );

    rdq_pos_stepper #(
        .PHASE_W (PHASE_W),
        .CSEL_W  (CSEL_W)
    ) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .step_i  (step),
        .phase_o (rd_phase_o),
        .csel_o  (rd_csel_o),
        .last_o  (last)
    );

    rdq_re_pulse #(
        .BURST_LEN (BURST_LEN)
    ) u_re (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .re_o   (rd_en_o)
    );

    // Adopted position: loaded only when a full pass run completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_phase_o <= '0;
            lock_csel_o  <= '0;
            done_o       <= 1'b0;
        end else if (lock_evt) begin
            lock_phase_o <= rd_phase_o;
            lock_csel_o  <= rd_csel_o;
            done_o       <= 1'b1;
        end
    end

    logic [PW-1:0] trial;
    assign trial = {rd_csel_o, rd_phase_o};

    p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> $stable({lock_csel_o, lock_phase_o, done_o}));

    p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$stable(trial)) |-> (trial == $past(trial) + 1'b1));

    p_start_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (trial == '0 && !fail_o));

    p_exhaust_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> (!busy_o && &$past(trial)));

    p_lock_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_o) && !busy_o && !fail_o) |-> ({lock_csel_o, lock_phase_o} == trial && done_o));
endmodule

// File: tb/rdq_read_train_tb_top.sv
`timescale 1ns/1ps
module rdq_read_train_tb_top;
    localparam int BL  = 8;
    localparam int PT  = 4;
    localparam int TO  = 16;
    localparam int NPOS = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, rd_ack_i = 1'b0, dvalid_i = 1'b0, bdet_i = 1'b0;
    logic busy_o, rd_req_o, rd_en_o, done_o, fail_o;
    logic [1:0] rd_phase_o, lock_phase_o;
    logic [2:0] rd_csel_o, lock_csel_o;

    int checks = 0;
    int errors = 0;
    bit fin = 1'b0;

    always #2.5 clk = ~clk;

    rdq_read_train #(.BURST_LEN(BL), .PASS_TARGET(PT), .TIMEOUT(TO)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
        .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .rd_en_o(rd_en_o),
        .dvalid_i(dvalid_i), .bdet_i(bdet_i), .rd_phase_o(rd_phase_o),
        .rd_csel_o(rd_csel_o), .done_o(done_o), .fail_o(fail_o),
        .lock_phase_o(lock_phase_o), .lock_csel_o(lock_csel_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int trial_idx();
        return {rd_csel_o, rd_phase_o};
    endfunction

    function automatic bit in_window(int idx, int tgt, int width);
        return (idx >= tgt) && (idx < tgt + width);
    endfunction

    // Read-enable width monitor (R1)
    int re_run = 0;
    always @(negedge clk) begin
        if (rd_en_o) re_run++;
        else begin
            if (re_run != 0) chk(re_run == BL / 4, "R1 rd_en width", re_run, BL / 4);
            re_run = 0;
        end
    end

    // One training run against a model window [tgt, tgt+width)
    task automatic run_train(input int tgt, input int width, input int drop_at,
                             input logic [31:0] silent, input int ignore_at);
        int exp_idx = 0, passes = 0, exp_lock = -1, idx, d, lat, cnt;
        bit finished = 0, exp_fail = 0, drop_pend, hit;
        logic [4:0] saved_lock;
        logic saved_done;
        saved_lock = {lock_csel_o, lock_phase_o};
        saved_done = done_o;
        drop_pend  = (drop_at >= 0);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(busy_o && !fail_o, "R8 start from idle", {busy_o, fail_o}, 2);
        chk(trial_idx() == 0, "R5 start position", trial_idx(), 0);
        while (!finished) begin
            while (!rd_req_o) @(negedge clk);
            idx = trial_idx();
            chk(idx == exp_idx, (idx == ignore_at + 1) ? "R8 start ignored, order kept" : "R5 search order", idx, exp_idx);
            chk({lock_csel_o, lock_phase_o} == saved_lock && done_o == saved_done,
                "R9 lock hold", {lock_csel_o, lock_phase_o}, saved_lock);
            d = $urandom_range(0, 2);
            repeat (d) @(negedge clk);
            rd_ack_i = 1'b1; bdet_i = 1'b0;
            @(negedge clk);
            rd_ack_i = 1'b0;
            chk(rd_en_o, "R1 rd_en starts after accept", rd_en_o, 1);
            if (idx == ignore_at) start_i = 1'b1;
            if (silent[idx]) begin
                cnt = 0;
                while (!rd_req_o && busy_o) begin
                    @(negedge clk); cnt++; start_i = 1'b0;
                end
                chk(cnt == TO, "R7 timeout miss", cnt, TO);
                passes = 0;
                if (idx == NPOS - 1) begin finished = 1; exp_fail = 1; end
                else exp_idx++;
            end else begin
                lat = $urandom_range(1, 5);
                repeat (lat) begin
                    @(negedge clk); start_i = 1'b0;
                    chk(!rd_req_o, "R2 no request while waiting", rd_req_o, 0);
                end
                dvalid_i = 1'b1;
                hit = in_window(idx, tgt, width);
                if (hit && drop_pend && idx == tgt && passes == drop_at) begin
                    hit = 0; drop_pend = 0;
                end
                @(negedge clk);
                dvalid_i = 1'b0; bdet_i = hit;
                chk(!rd_req_o, "R2 no request before sample", rd_req_o, 0);
                @(negedge clk);
                if (hit) begin
                    passes++;
                    if (passes == PT) begin finished = 1; exp_lock = idx; end
                end else begin
                    passes = 0;
                    if (idx == NPOS - 1) begin finished = 1; exp_fail = 1; end
                    else exp_idx++;
                end
                if (finished) chk(!busy_o, "R3/R6 training ends", busy_o, 0);
                else chk(rd_req_o, hit ? "R3 next read after pass" : "R4 next read after miss", rd_req_o, 1);
            end
        end
        while (busy_o) @(negedge clk);
        if (exp_fail) begin
            chk(fail_o, "R6 fail raised", fail_o, 1);
            chk({lock_csel_o, lock_phase_o} == saved_lock && done_o == saved_done,
                "R6 lock kept on fail", {lock_csel_o, lock_phase_o}, saved_lock);
        end else begin
            chk(!fail_o && done_o, "R3 done set", {done_o, fail_o}, 2);
            chk({lock_csel_o, lock_phase_o} == exp_lock, "R3 lock value",
                {lock_csel_o, lock_phase_o}, exp_lock);
        end
        bdet_i = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        chk({busy_o, rd_req_o, rd_en_o, done_o, fail_o} == 0, "R10 reset flags",
            {busy_o, rd_req_o, rd_en_o, done_o, fail_o}, 0);
        chk({rd_csel_o, rd_phase_o, lock_csel_o, lock_phase_o} == 0, "R10 reset codes",
            {rd_csel_o, rd_phase_o, lock_csel_o, lock_phase_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o, "R8 idle without start", busy_o, 0);
        run_train(5, 1, -1, 32'h0, -1);
        run_train(10, 2, 2, 32'h0, 3);
        run_train(3, 1, -1, 32'h7, -1);
        run_train(99, 0, -1, 32'h8000_0001, -1);
        run_train(31, 1, 0, 32'h0, -1);
        run_train(31, 1, -1, 32'h0, -1);
        for (int k = 0; k < 6; k++) begin
            int t, w, dr;
            logic [31:0] sm;
            t  = $urandom_range(0, 31);
            w  = $urandom_range(1, 3);
            dr = ($urandom_range(0, 1) == 1) ? $urandom_range(0, PT - 1) : -1;
            sm = $urandom & $urandom & $urandom;
            run_train(t, w, dr, sm, $urandom_range(0, 8));
        end
        fin = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule